// File: doc/BRIEF.md
# Intersection Signal Property Monitor

This block is a runtime checker placed next to a three-approach traffic-signal controller that serves a north, a south and an east approach. On every clock it samples the three vehicle-sensor bits and the three green ("go") bits that the controller produces. It never drives the lights. It only records rule breaks in sticky flags.

The monitor checks the following rules:
- Mutual exclusion between the east green and the north/south pair.
- A response rule: a waiting approach must be served. The open-ended "eventually" is replaced by a bounded wait of `MAX_WAIT` cycles.
- A hold rule: a sensor that is raised must stay raised until its green arrives.
- A fairness assumption: no approach may keep its green and its sensor both high for longer than `MAX_HOLD` cycles.

Because the response rule is only meaningful under fairness, starvation reports are masked while a fairness break is on record. Every flag stays set until a synchronous reset. One summary output reports any recorded break.

Top module: `signal_rule_monitor`

## Requirements
- R1: Vectors are indexed 0 = north, 1 = south, 2 = east. If `go_i[2]` is high together with `go_i[0]` or `go_i[1]` on a sampled edge, `collision_o` is high from the next cycle on.
- R2: North and south green together with east green low never sets `collision_o`.
- R3: For each approach, a sampled cycle with its sense high and its go low is "waiting". If an approach was waiting on one edge and has both sense and go low on the next edge, that approach's `withdraw_o` bit is set from the following cycle.
- R4: For each approach, a run of `MAX_WAIT` consecutive waiting edges sets that approach's bit in the internal starvation record. A run is cleared by any edge that is not waiting.
- R5: For each approach, a run of more than `MAX_HOLD` consecutive edges with both go and sense high sets `fair_viol_o`.
- R6: While `fair_viol_o` is high, every bit of `starve_o` reads 0. Otherwise `starve_o` shows the starvation record.
- R7: All flags are sticky until reset. `err_o` is the OR of `collision_o`, `fair_viol_o`, `starve_o` and `withdraw_o`.
- R8: A high `rst` on a clock edge clears every flag. After that edge, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| sense_i | input | 3 | Sensor bits: [0] north, [1] south, [2] east |
| go_i | input | 3 | Green bits from the watched controller, same indexing |
| collision_o | output | 1 | Sticky: east green overlapped north or south green |
| starve_o | output | 3 | Sticky per approach: wait limit reached (masked under fairness break) |
| withdraw_o | output | 3 | Sticky per approach: sensor dropped before being served |
| fair_viol_o | output | 1 | Sticky: go and sense both held beyond the hold limit |
| err_o | output | 1 | OR of all flags |

## Verification
Every flag is one register stage behind the edge that samples its cause. A collision or withdraw is visible one cycle after the offending inputs. Starvation becomes visible after the `MAX_WAIT`-th waiting edge. A fairness break becomes visible after edge `MAX_HOLD+1` of a hold run. `starve_o` and `err_o` follow the registers combinationally.

The bench drives inputs just after the falling edge, so they are stable before the next rising edge. A behavioural model updates on each rising edge. All outputs are compared with the model at the following falling edge, which is exactly when each registered result is due. The bench replays two scenarios: a north-on/south-off overlap with east green, and a lock that is never released so east starves. Explicit checks in each scenario pin the expected values.

// File: rtl/sigmon_pkg.sv
package sigmon_pkg;

  localparam int unsigned NDIR  = 3;
  localparam int unsigned DIR_N = 0;
  localparam int unsigned DIR_S = 1;
  localparam int unsigned DIR_E = 2;

  // length of a consecutive run after one more sample, saturating at lim
  function automatic int unsigned run_next(int unsigned cur, logic act, int unsigned lim);
    if (!act) return 0;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

  // conflict between the crossing approach and the shared-lock pair
  function automatic logic crosses(logic [NDIR-1:0] go);
    return go[DIR_E] & (go[DIR_N] | go[DIR_S]);
  endfunction

endpackage

// File: rtl/sigmon_dir_watch.sv
module sigmon_dir_watch
  import sigmon_pkg::*;
#(
  parameter int unsigned MAX_WAIT = 16,
  parameter int unsigned MAX_HOLD = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic sense,
  input  logic go,
  output logic starve_q,
  output logic hold_q,
  output logic wdraw_q
);

  localparam int unsigned WW = $clog2(MAX_WAIT + 1);
  localparam int unsigned HW = $clog2(MAX_HOLD + 1);

  logic [WW-1:0] wcnt_q;
  logic [HW-1:0] hcnt_q;
  logic          pend_q;

  // named events for the assertions
  logic waiting, served_hold, dropped, wait_hit, hold_hit;
  int unsigned wnext, hnext;

  always_comb begin
    waiting     = sense & ~go;
    served_hold = sense & go;
    dropped     = pend_q & ~sense & ~go;
    wnext       = run_next(int'(wcnt_q), waiting, MAX_WAIT);
    hnext       = run_next(int'(hcnt_q), served_hold, MAX_HOLD + 1);
    wait_hit    = waiting & (wnext >= MAX_WAIT);
    hold_hit    = served_hold & (hnext > MAX_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q   <= '0;
      hcnt_q   <= '0;
      pend_q   <= 1'b0;
      starve_q <= 1'b0;
      hold_q   <= 1'b0;
      wdraw_q  <= 1'b0;
    end else begin
      wcnt_q   <= WW'(wnext);
      hcnt_q   <= (hnext > MAX_HOLD) ? HW'(MAX_HOLD) : HW'(hnext);
      pend_q   <= waiting;
      starve_q <= starve_q | wait_hit;
      hold_q   <= hold_q | hold_hit;
      wdraw_q  <= wdraw_q | dropped;
    end
  end

  // R4
  starve_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (waiting && int'(wcnt_q) == MAX_WAIT - 1) |=> starve_q);

  // R4
  wait_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(wcnt_q) <= MAX_WAIT);

  // R3
  withdraw_seen_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !sense && !go) |=> wdraw_q);

  // R7
  starve_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    starve_q |=> starve_q);

endmodule

// File: rtl/signal_rule_monitor.sv
module signal_rule_monitor
  import sigmon_pkg::*;
#(
  parameter int unsigned MAX_WAIT = 16,
  parameter int unsigned MAX_HOLD = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sense_i,
  input  logic [2:0] go_i,
  output logic       collision_o,
  output logic [2:0] starve_o,
  output logic [2:0] withdraw_o,
  output logic       fair_viol_o,
  output logic       err_o
);

  logic [NDIR-1:0] starve_raw, hold_raw, wdraw_raw;
  logic            clash, coll_q;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    sigmon_dir_watch #(
      .MAX_WAIT(MAX_WAIT),
      .MAX_HOLD(MAX_HOLD)
    ) u_watch (
      .clk     (clk),
      .rst     (rst),
      .sense   (sense_i[d]),
      .go      (go_i[d]),
      .starve_q(starve_raw[d]),
      .hold_q  (hold_raw[d]),
      .wdraw_q (wdraw_raw[d])
    );
  end

  assign clash = crosses(go_i);

  always_ff @(posedge clk) begin
    if (rst) coll_q <= 1'b0;
    else     coll_q <= coll_q | clash;
  end

  assign collision_o = coll_q;
  assign fair_viol_o = |hold_raw;
  assign starve_o    = fair_viol_o ? '0 : starve_raw;
  assign withdraw_o  = wdraw_raw;
  assign err_o       = coll_q | fair_viol_o | (|starve_o) | (|wdraw_raw);

  // R1
  collision_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (go_i[2] && (go_i[0] || go_i[1])) |=> collision_o);

  // R2
  pair_no_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(collision_o) && !go_i[2]) |=> (collision_o == $past(collision_o)));

  // R7
  collision_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    collision_o |=> collision_o);

  // R6
  starve_mask_chk: assert property (@(posedge clk) disable iff (rst)
    fair_viol_o |-> (starve_o == 3'b000));

  // R7
  err_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (collision_o || withdraw_o != 3'b000) |-> err_o);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!collision_o && !fair_viol_o && withdraw_o == 3'b000));

endmodule

// File: tb/signal_rule_monitor_tb_top.sv
module signal_rule_monitor_tb_top;

  localparam int MAX_WAIT = 16;
  localparam int MAX_HOLD = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sense_i = '0;
  logic [2:0] go_i = '0;
  logic       collision_o, fair_viol_o, err_o;
  logic [2:0] starve_o, withdraw_o;

  int compared = 0;
  int mismatched = 0;
  bit started = 0;

  always #10 clk = ~clk;

  signal_rule_monitor #(.MAX_WAIT(MAX_WAIT), .MAX_HOLD(MAX_HOLD)) dut_i (
    .clk(clk), .rst(rst), .sense_i(sense_i), .go_i(go_i),
    .collision_o(collision_o), .starve_o(starve_o), .withdraw_o(withdraw_o),
    .fair_viol_o(fair_viol_o), .err_o(err_o)
  );

  // behavioural reference model
  int  m_wait[3], m_hold[3];
  bit  m_prevwait[3];
  bit  m_coll, m_fair;
  bit  m_starve[3], m_wd[3];

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_coll = 0; m_fair = 0;
      foreach (m_wait[d]) begin
        m_wait[d] = 0; m_hold[d] = 0; m_prevwait[d] = 0;
        m_starve[d] = 0; m_wd[d] = 0;
      end
    end else begin
      if (go_i[2] && (go_i[0] || go_i[1])) m_coll = 1;
      for (int d = 0; d < 3; d++) begin
        bit w;
        w = sense_i[d] && !go_i[d];
        if (w) m_wait[d]++; else m_wait[d] = 0;
        if (m_wait[d] >= MAX_WAIT) m_starve[d] = 1;
        if (sense_i[d] && go_i[d]) m_hold[d]++; else m_hold[d] = 0;
        if (m_hold[d] > MAX_HOLD) m_fair = 1;
        if (m_prevwait[d] && !sense_i[d] && !go_i[d]) m_wd[d] = 1;
        m_prevwait[d] = w;
      end
    end
  end

  task automatic check(string req, int act, int exp_v);
    compared++;
    if (act != exp_v) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  function automatic logic [2:0] pack3(bit b[3]);
    return {b[2], b[1], b[0]};
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      logic [2:0] ms, mw;
      ms = m_fair ? 3'b000 : pack3(m_starve);
      mw = pack3(m_wd);
      check("R1 collision", collision_o, m_coll);
      check("R4/R6 starve", starve_o, ms);
      check("R3 withdraw", withdraw_o, mw);
      check("R5 fair", fair_viol_o, m_fair);
      check("R7 err", err_o, m_coll | m_fair | (|ms) | (|mw));
    end
  end

  task automatic cyc(logic [2:0] s, logic [2:0] g, int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      sense_i = s; go_i = g;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #2;
    rst = 1; sense_i = '0; go_i = '0;
    @(negedge clk); #2;
    rst = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst = 0;
    @(negedge clk);
    // R8 reset state
    check("R8 reset outputs", {collision_o, starve_o, withdraw_o, fair_viol_o, err_o}, 0);

    // R2 north and south green together, normal service
    cyc(3'b011, 3'b000, 2);
    cyc(3'b011, 3'b011, 4);
    cyc(3'b000, 3'b011, 1);
    cyc(3'b100, 3'b000, 3);
    cyc(3'b100, 3'b100, 3);
    cyc(3'b000, 3'b000, 2);
    @(negedge clk);
    check("R2 pair compatible", collision_o, 0);
    check("R2 no error", err_o, 0);

    // scenario 1: north on as south goes off while east is green -> R1
    cyc(3'b010, 3'b010, 2);
    cyc(3'b101, 3'b101, 1);
    cyc(3'b000, 3'b000, 2);
    @(negedge clk);
    check("R1 overlap caught", collision_o, 1);
    check("R7 collision sticky err", err_o, 1);

    // R8 reset clears
    do_reset();
    @(negedge clk);
    check("R8 cleared", {collision_o, err_o}, 0);

    // scenario 2: N and S drop together, lock stuck, east waits -> R4
    cyc(3'b011, 3'b011, 2);
    cyc(3'b100, 3'b000, MAX_WAIT - 1);
    @(negedge clk); #1;
    check("R4 not yet starved", starve_o[2], 0);
    cyc(3'b100, 3'b000, 3);
    @(negedge clk);
    check("R4 east starved", starve_o[2], 1);
    check("R4 north not starved", starve_o[0], 0);

    // R5/R6 fairness break masks starvation
    cyc(3'b001, 3'b001, MAX_HOLD);
    @(negedge clk); #1;
    check("R5 hold at limit ok", fair_viol_o, 0);
    cyc(3'b001, 3'b001, 2);
    @(negedge clk);
    check("R5 hold exceeded", fair_viol_o, 1);
    check("R6 starve masked", starve_o, 0);

    // R3 withdraw of a waiting sensor
    do_reset();
    cyc(3'b010, 3'b000, 2);
    cyc(3'b000, 3'b000, 2);
    @(negedge clk);
    check("R3 south withdraw", withdraw_o, 3'b010);
    check("R7 withdraw err", err_o, 1);

    // R4 wait run broken by a sensor drop does not starve (but R3 flags the drop)
    do_reset();
    cyc(3'b001, 3'b000, MAX_WAIT - 1);
    cyc(3'b000, 3'b000, 1);
    cyc(3'b001, 3'b000, MAX_WAIT - 1);
    cyc(3'b001, 3'b001, 2);
    cyc(3'b000, 3'b000, 2);
    @(negedge clk);
    check("R4 broken run no starve", starve_o[0], 0);

    cyc(3'b000, 3'b000, 2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule